// File: doc/BRIEF.md
# Performance Counter CSR Unit

This block is the machine-level counter register file of a 32-bit core. It keeps a free-running clock-cycle counter, a retired-instruction counter and six programmable event counters, all 64 bits wide. Each event counter has its own 5-bit selector. The selector picks one of 22 single-cycle event strobes that the pipeline, the caches and the TLBs send in. A counter-inhibit register stops any implemented counter on its own bit.

Software reaches the unit through a plain CSR port: a 12-bit address, a 2-bit operation (none, write, set bits, clear bits) and 32 bits of write data. Read data is combinational for the address presented in the same cycle. There is no data stream, so the port has no handshake. An operation takes effect at the clock edge that ends the cycle in which it is presented, and the port accepts an operation every cycle.

Each 64-bit counter is seen as two 32-bit halves. A read-only user-level alias page mirrors every counter. Counter slots that are not built read as zero, and a parameter can drop the six event counters altogether. Privilege checks and trap generation belong to the surrounding CSR file.

Top module: `perf_counter_csr`

## Requirements
- R1: `csr_op_i` encodes 0 = no operation, 1 = write, 2 = set the bits that are 1 in `csr_wdata_i`, 3 = clear the bits that are 1 in `csr_wdata_i`. A set or clear works on the value currently read at `csr_addr_i`, and the new value is in place after the next rising clock edge.
- R2: The cycle counter (slot 0) adds 1 on every clock edge while inhibit bit 0 is 0.
- R3: The retired-instruction counter (slot 2) adds `retire_cnt_i` on every clock edge while inhibit bit 2 is 0.
- R4: Event counter N (slots 3 to 8) has a selector at address 0x320+N. The selector stores only the low 5 bits of the write data and reads back zeros above them. Selector value k from 1 to 22 counts `event_i[k-1]`, adding 1 per edge. Value 0 and values 23 to 31 leave the counter unchanged.
- R5: The inhibit register is at 0x320. Bit 0 gates the cycle counter, bit 2 the retired-instruction counter and bit N event counter N. A 1 stops the counter, and bits of counters that are not built read as 0.
- R6: `rst_ni` is asynchronous and active low. It clears every counter, every selector and the inhibit register, so all counters run after reset.
- R7: Bits 31:0 of counter slot i are at 0xB00+i and bits 63:32 are at 0xB80+i. The count carries from the low half into the high half.
- R8: A write, set or clear to one half of a counter in the same cycle as an increment wins. The addressed half takes the new value, the other half keeps its old value, and no increment happens on that edge.
- R9: The read-only page at 0xC00+i (low) and 0xC80+i (high) returns the same data as 0xB00+i and 0xB80+i. Any operation on that page changes nothing.
- R10: Counter slot 1, counter slots 9 to 31, selector addresses 0x321, 0x322 and 0x329 to 0x33F, and every other unlisted address read 0. Writes to them change nothing.
- R11: With `EVENTS_EN` = 0 the event counters and their selectors read 0 and ignore writes, and inhibit bits 3 to 8 read 0. The cycle and retired-instruction counters still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_op_i | input | 2 | CSR operation: 0 none, 1 write, 2 set, 3 clear |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Write data or bit mask |
| retire_cnt_i | input | RET_W | Instructions retired this cycle |
| event_i | input | NUM_EVENTS | One-cycle event strobes; bit k-1 is event ID k |
| csr_rdata_o | output | 32 | Read data for `csr_addr_i`, combinational |

## Verification
All counters are first frozen through the inhibit register. Writes, sets and clears then have exactly known results, which separates the three operation codes and shows which addresses hold storage and which read zero.

Each counter is then released alone for a counted number of edges:
- A cycle counter preloaded just below the 32-bit boundary shows the carry into the high half.
- A write during counting shows that the written value wins and the other half is kept.
- A varying retire count shows that the counter adds the amount and not just one.

Event strobes are driven as all-ones, as a single high bit and as all-but-one-bit. Together with selector values 0, 5, 22 and 23, these patterns separate correct ID-to-strobe mapping from an off-by-one index or from counting on reserved IDs. A second instance built without event counters reads every event address as zero.

// File: rtl/perf_csr_pkg.sv
`timescale 1ns/1ps
package perf_csr_pkg;

  typedef enum logic [1:0] {
    CSR_NOP   = 2'd0,
    CSR_WRITE = 2'd1,
    CSR_SET   = 2'd2,
    CSR_CLEAR = 2'd3
  } csr_op_e;

  // address pages: csr_addr[11:5]; csr_addr[4:0] picks the slot
  localparam logic [6:0] PG_CTR_LO = 7'h58;  // 0xB00
  localparam logic [6:0] PG_CTR_HI = 7'h5C;  // 0xB80
  localparam logic [6:0] PG_SHD_LO = 7'h60;  // 0xC00
  localparam logic [6:0] PG_SHD_HI = 7'h64;  // 0xC80
  localparam logic [6:0] PG_CTRL   = 7'h19;  // 0x320: slot 0 inhibit, slot N selector

  function automatic logic [31:0] csr_apply(csr_op_e op, logic [31:0] cur, logic [31:0] arg);
    case (op)
      CSR_WRITE: return arg;
      CSR_SET:   return cur | arg;
      CSR_CLEAR: return cur & ~arg;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/perf_event_pick.sv
`timescale 1ns/1ps
module perf_event_pick #(
  parameter int NUM_EVENTS = 22,
  parameter int SEL_W      = 5
) (
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [NUM_EVENTS-1:0] events_i,
  output logic                  hit_o
);
  // ID 0 and IDs above NUM_EVENTS match no strobe
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < NUM_EVENTS; k++) begin
      if (sel_i == SEL_W'(k + 1)) hit_o = events_i[k];
    end
  end
endmodule

// File: rtl/perf_counter64.sv
`timescale 1ns/1ps
module perf_counter64 #(
  parameter int CNT_W = 64,
  parameter int INC_W = 2,
  localparam int HALF = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_en_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [HALF-1:0]  wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_lo_i)  cnt_q <= {cnt_q[CNT_W-1:HALF], wdata_i};
    else if (wr_hi_i)  cnt_q <= {wdata_i, cnt_q[HALF-1:0]};
    else if (inc_en_i) cnt_q <= cnt_q + CNT_W'(inc_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/perf_counter_csr.sv
`timescale 1ns/1ps
module perf_counter_csr
  import perf_csr_pkg::*;
#(
  parameter int NUM_EVT_CTR = 6,
  parameter int NUM_EVENTS  = 22,
  parameter int SEL_W       = 5,
  parameter int RET_W       = 2,
  parameter bit EVENTS_EN   = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            csr_op_i,
  input  logic [11:0]           csr_addr_i,
  input  logic [31:0]           csr_wdata_i,
  input  logic [RET_W-1:0]      retire_cnt_i,
  input  logic [NUM_EVENTS-1:0] event_i,
  output logic [31:0]           csr_rdata_o
);
  localparam int FIRST_EVT = 3;
  localparam int NSLOT     = FIRST_EVT + NUM_EVT_CTR;  // slots 0..NSLOT-1, must stay <= 32

  function automatic logic [NSLOT-1:0] impl_slots();
    logic [NSLOT-1:0] m;
    m = '0;
    for (int k = 0; k < NSLOT; k++)
      m[k] = (k == 0) || (k == 2) || ((k >= FIRST_EVT) && EVENTS_EN);
    return m;
  endfunction

  localparam logic [NSLOT-1:0] IMPL = impl_slots();

  logic [NSLOT-1:0][63:0]      ctr_all;
  logic [NSLOT-1:0][SEL_W-1:0] sel_all;
  logic [NSLOT-1:0]            inh_q;
  logic [6:0]                  page;
  logic [4:0]                  idx;
  logic [31:0]                 rd;
  logic [31:0]                 wval;
  logic                        wr_any;

  assign page   = csr_addr_i[11:5];
  assign idx    = csr_addr_i[4:0];
  assign wr_any = (csr_op_i != 2'd0);

  // read multiplexer; absent slots are tied to zero below
  always_comb begin
    rd = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (idx == 5'(k)) begin
        if (page == PG_CTR_LO || page == PG_SHD_LO)      rd = ctr_all[k][31:0];
        else if (page == PG_CTR_HI || page == PG_SHD_HI) rd = ctr_all[k][63:32];
        else if (page == PG_CTRL) begin
          if (k == 0)              rd = 32'(inh_q);
          else if (k >= FIRST_EVT) rd = 32'(sel_all[k]);
        end
      end
    end
  end

  assign csr_rdata_o = rd;
  assign wval        = csr_apply(csr_op_e'(csr_op_i), rd, csr_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      inh_q <= '0;
    else if (wr_any && page == PG_CTRL && idx == 5'd0)
      inh_q <= wval[NSLOT-1:0] & IMPL;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (!IMPL[k]) begin : g_absent
      assign ctr_all[k] = '0;
      assign sel_all[k] = '0;
    end else begin : g_present
      logic [RET_W-1:0] step;
      logic             wr_lo;
      logic             wr_hi;

      assign wr_lo = wr_any && (page == PG_CTR_LO) && (idx == 5'(k));
      assign wr_hi = wr_any && (page == PG_CTR_HI) && (idx == 5'(k));

      if (k == 0) begin : g_cycle
        assign step       = RET_W'(1);
        assign sel_all[k] = '0;
      end else if (k == 2) begin : g_retire
        assign step       = retire_cnt_i;
        assign sel_all[k] = '0;
      end else begin : g_event
        logic [SEL_W-1:0] sel_q;
        logic             hit;

        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)
            sel_q <= '0;
          else if (wr_any && page == PG_CTRL && idx == 5'(k))
            sel_q <= wval[SEL_W-1:0];
        end

        perf_event_pick #(
          .NUM_EVENTS(NUM_EVENTS),
          .SEL_W     (SEL_W)
        ) u_pick (
          .sel_i   (sel_q),
          .events_i(event_i),
          .hit_o   (hit)
        );

        assign step       = RET_W'(hit);
        assign sel_all[k] = sel_q;
      end

      perf_counter64 #(
        .CNT_W(64),
        .INC_W(RET_W)
      ) u_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_en_i(!inh_q[k]),
        .inc_i   (step),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .wdata_i (wval),
        .cnt_o   (ctr_all[k])
      );
    end
  end
endmodule

// File: rtl/perf_counter_csr_chk.sv
`timescale 1ns/1ps
module perf_counter_csr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  csr_op_i,
  input logic [11:0] csr_addr_i,
  input logic [31:0] csr_wdata_i,
  input logic [31:0] csr_rdata_o,
  input logic [63:0] cyc_i,
  input logic [63:0] evt_i,
  input logic [4:0]  sel_i,
  input logic        inh_cyc_i
);
  // R2
  cycle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(inh_cyc_i) && $past(csr_op_i) == 2'd0)
      |-> cyc_i == $past(cyc_i) + 64'd1);

  // R5
  cycle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(inh_cyc_i) && $past(csr_op_i) == 2'd0)
      |-> cyc_i == $past(cyc_i));

  // R8
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(csr_op_i) == 2'd1 && $past(csr_addr_i) == 12'hB00)
      |-> (cyc_i[31:0] == $past(csr_wdata_i) && cyc_i[63:32] == $past(cyc_i[63:32])));

  // R4
  idle_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(csr_op_i) == 2'd0 && ($past(sel_i) == 5'd0 || $past(sel_i) > 5'd22))
      |-> evt_i == $past(evt_i));

  // R10
  absent_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i[11:5] == 7'h58 && csr_addr_i[4:0] >= 5'd9) |-> csr_rdata_o == 32'd0);

  // R9
  alias_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == 12'hC00) |-> csr_rdata_o == cyc_i[31:0]);
endmodule

bind perf_counter_csr perf_counter_csr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .csr_op_i   (csr_op_i),
  .csr_addr_i (csr_addr_i),
  .csr_wdata_i(csr_wdata_i),
  .csr_rdata_o(csr_rdata_o),
  .cyc_i      (ctr_all[0]),
  .evt_i      (ctr_all[3]),
  .sel_i      (sel_all[3]),
  .inh_cyc_i  (inh_q[0])
);

// File: tb/perf_counter_csr_test.sv
`timescale 1ns/1ps
module perf_counter_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [11:0] addr = 12'd0;
  logic [31:0] wdata = 32'd0;
  logic [1:0]  retire = 2'd0;
  logic [21:0] events = 22'd0;
  logic [31:0] rdata;
  logic [31:0] rdata_lite;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  perf_counter_csr uut (
    .clk_i(clk), .rst_ni(rst_n), .csr_op_i(op), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .retire_cnt_i(retire), .event_i(events), .csr_rdata_o(rdata)
  );

  perf_counter_csr #(.EVENTS_EN(1'b0)) uut_lite (
    .clk_i(clk), .rst_ni(rst_n), .csr_op_i(op), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .retire_cnt_i(retire), .event_i(events), .csr_rdata_o(rdata_lite)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] waddr;
    logic [31:0] wdata;
    logic [11:0] raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // run with every counter inhibited so values are exact
  localparam vec_t VECS [12] = '{
    '{2'd1, 12'hB03, 32'h12345678, 12'hB03, 32'h12345678, 4'd7},   // R7 low half
    '{2'd1, 12'hB83, 32'hCAFEF00D, 12'hB83, 32'hCAFEF00D, 4'd7},   // R7 high half
    '{2'd2, 12'hB03, 32'h0000000F, 12'hB03, 32'h1234567F, 4'd1},   // R1 set
    '{2'd3, 12'hB03, 32'hF0000000, 12'hB03, 32'h0234567F, 4'd1},   // R1 clear
    '{2'd1, 12'hB10, 32'hFFFFFFFF, 12'hB10, 32'h00000000, 4'd10},  // R10 slot 16
    '{2'd1, 12'h32A, 32'h0000001F, 12'h32A, 32'h00000000, 4'd10},  // R10 selector 10
    '{2'd1, 12'h324, 32'hFFFFFFFF, 12'h324, 32'h0000001F, 4'd4},   // R4 5-bit selector
    '{2'd1, 12'hC03, 32'h00000001, 12'hC03, 32'h0234567F, 4'd9},   // R9 alias write ignored
    '{2'd0, 12'h000, 32'h00000000, 12'hC83, 32'hCAFEF00D, 4'd9},   // R9 alias high
    '{2'd1, 12'hB00, 32'hFFFFFFFF, 12'hC00, 32'hFFFFFFFF, 4'd9},   // R9 alias cycle
    '{2'd0, 12'h000, 32'h00000000, 12'hB01, 32'h00000000, 4'd10},  // R10 slot 1
    '{2'd1, 12'hB81, 32'h12345678, 12'hB81, 32'h00000000, 4'd10}   // R10 slot 1 high
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // called at a negedge; exactly one rising edge applies the operation
  task automatic do_op(input logic [1:0] o, input logic [11:0] a, input logic [31:0] d);
    op = o; addr = a; wdata = d;
    @(negedge clk);
    op = 2'd0;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a; op = 2'd0;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic lite_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a; op = 2'd0;
    #1;
    check(req, rdata_lite, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    read_chk("R6 cycle in reset", 12'hB00, 32'd0);
    read_chk("R6 inhibit in reset", 12'h320, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    read_chk("R6 instret after reset", 12'hB02, 32'd0);
    read_chk("R6 event ctr after reset", 12'hB03, 32'd0);

    do_op(2'd1, 12'h320, 32'hFFFFFFFF);
    read_chk("R5 inhibit mask", 12'h320, 32'h000001FD);
    lite_chk("R11 lite inhibit mask", 12'h320, 32'h00000005);

    for (int i = 0; i < 12; i++) begin
      do_op(VECS[i].op, VECS[i].waddr, VECS[i].wdata);
      read_chk($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].raddr, VECS[i].exp);
    end

    lite_chk("R11 lite event ctr low", 12'hB03, 32'd0);
    lite_chk("R11 lite event ctr high", 12'hB83, 32'd0);
    lite_chk("R11 lite selector", 12'h324, 32'd0);
    lite_chk("R11 lite cycle kept", 12'hB00, 32'hFFFFFFFF);

    // cycle counter: carry, counting, write priority, inhibit
    do_op(2'd1, 12'hB80, 32'd0);
    do_op(2'd1, 12'hB00, 32'hFFFFFFFE);
    do_op(2'd1, 12'h320, 32'h000001FC);
    repeat (2) @(negedge clk);
    read_chk("R7 carry low", 12'hB00, 32'd0);
    read_chk("R7 carry high", 12'hB80, 32'd1);
    repeat (3) @(negedge clk);
    read_chk("R2 cycle count", 12'hB00, 32'd3);
    do_op(2'd1, 12'hB00, 32'h00000100);
    read_chk("R8 written half", 12'hB00, 32'h00000100);
    read_chk("R8 other half kept", 12'hB80, 32'd1);
    do_op(2'd1, 12'h320, 32'h000001FD);
    repeat (4) @(negedge clk);
    read_chk("R5 cycle frozen", 12'hB00, 32'h00000101);

    // retired instructions
    retire = 2'd2;
    do_op(2'd1, 12'hB02, 32'd0);
    do_op(2'd1, 12'hB82, 32'd0);
    do_op(2'd1, 12'h320, 32'h000001F9);
    repeat (3) @(negedge clk);
    read_chk("R3 instret by 2", 12'hB02, 32'd6);
    retire = 2'd3;
    repeat (2) @(negedge clk);
    read_chk("R3 instret by 3", 12'hB02, 32'd12);
    do_op(2'd1, 12'h320, 32'h000001FD);
    repeat (2) @(negedge clk);
    read_chk("R5 instret frozen", 12'hB02, 32'd15);
    read_chk("R9 instret alias", 12'hC02, 32'd15);
    retire = 2'd0;

    // event counter 3
    events = 22'h3FFFFF;
    do_op(2'd1, 12'h323, 32'd5);
    do_op(2'd1, 12'hB03, 32'd0);
    do_op(2'd1, 12'hB83, 32'd0);
    do_op(2'd1, 12'h320, 32'h000001F5);
    repeat (4) @(negedge clk);
    read_chk("R4 id 5 counts", 12'hB03, 32'd4);
    do_op(2'd1, 12'h323, 32'd23);
    repeat (3) @(negedge clk);
    read_chk("R4 reserved id 23", 12'hB03, 32'd5);
    do_op(2'd1, 12'h323, 32'd0);
    repeat (2) @(negedge clk);
    read_chk("R4 id 0", 12'hB03, 32'd5);
    events = 22'h200000;
    do_op(2'd1, 12'h323, 32'd22);
    repeat (3) @(negedge clk);
    read_chk("R4 id 22 uses top strobe", 12'hB03, 32'd8);
    events = 22'h1FFFFF;
    repeat (2) @(negedge clk);
    read_chk("R4 id 22 ignores others", 12'hB03, 32'd8);
    events = 22'h000010;
    do_op(2'd1, 12'h323, 32'd5);
    repeat (2) @(negedge clk);
    read_chk("R4 id 5 uses strobe 4", 12'hB03, 32'd10);
    do_op(2'd1, 12'h320, 32'h000001FD);
    read_chk("R9 event alias", 12'hC03, 32'd11);
    read_chk("R5 event frozen", 12'hB03, 32'd11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule